// File: doc/BRIEF.md
# Task-Event UART Register Front End

This block is the software-facing half of a UART. A processor drives it through 32-bit register reads and writes. Control is by task registers: writing the value 1 to a task starts or stops transmit or receive. Status is kept in sticky event registers, which software may also write directly. One interrupt line is raised when any enabled event is set. The mask has a direct register plus set and clear aliases. An error-source register records line breaks and is cleared by writing ones to it.

On the serial side it talks to a bit shifter through byte streams. Outgoing bytes leave one at a time from a single holding register with a valid/ready handshake. Incoming bytes fill a small circular receive FIFO while reception is running, and the block reports how much room is left. A break input marks a line break. Until software writes a nonzero value to the enable register, every other register write is ignored.

Top module: `uart_task_regs`

## Requirements
- R1: `irq` is high exactly when some event bit and the same mask bit are both 1. Event and mask bit positions are: bit0 receive-ready, bit1 transmit-ready, bit2 error, bit3 receive-timeout.
- R2: A write to the mask register (0x080) stores wdata[3:0]. A write to the set alias (0x084) ORs wdata[3:0] into the mask. A write to the clear alias (0x088) clears the mask bits where wdata is 1. A mask read returns the mask in bits [3:0] with zeros above.
- R3: A one-cycle pulse on `break_in` sets error-source bits [1:0] (register 0x0C0) and the error event. Writing the error-source register clears each bit written as 1 and leaves the error event unchanged.
- R4: The block is enabled while the enable register (0x0C4) holds a nonzero value. While it is disabled, every write except one to 0x0C4 is ignored.
- R5: A write to transmit-data (0x104) is accepted only if transmit is started and no byte is pending. An accepted byte raises `tx_valid` with `tx_data`, and the byte is held until `tx_ready`. When the byte is taken, `tx_valid` falls and the transmit-ready event sets. Writes made while a byte is pending are ignored.
- R6: A task fires only when the value written is 1. Start-receive is 0x000 and stop-receive is 0x004; start-transmit is 0x008 and stop-transmit is 0x00C. Stop-receive clears the receive-started state and sets the receive-timeout event. Stop-transmit clears only the transmit-started state.
- R7: A read of receive-data (0x100) returns the oldest FIFO byte in bits [7:0]. If reception is started and the FIFO holds data, the read removes that byte. After the removal, the receive-ready event sets again if bytes remain.
- R8: `rx_ready` is high only while reception is started and the 6-entry FIFO is not full. `rx_space` equals 6 minus the count while reception is started, and 0 otherwise. Each stored byte sets the receive-ready event, and FIFO storage wraps around.
- R9: After reset, transmit and receive are stopped and no byte is pending. The four pin-select registers (0x180, 0x184, 0x188, 0x18C) read 0xFFFFFFFF and the baud register (0x140) reads 0x04000000. All other registers read 0 and `irq` is low.
- R10: The event registers are at 0x040, 0x044, 0x048 and 0x04C, in bit order 0..3. Writing a nonzero value sets an event and writing 0 clears it. A read returns the event in bit 0.
- R11: Reads of unmapped offsets, task registers, mask aliases and transmit-data return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd_en` |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_data | output | 8 | Pending transmit byte |
| tx_ready | input | 1 | Shifter takes the pending byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block stores the incoming byte this cycle |
| rx_space | output | CNT_W | Free FIFO entries while receiving |
| break_in | input | 1 | Line-break indication pulse |
| irq | output | 1 | Level interrupt |

## Verification
Most internal state in this block shows at the ports within one register access. A wrong FIFO head or count shows in the next receive-data read, and in `rx_space` on the cycle after a push or pop. A stuck pending flag shows at once on `tx_valid`, and a lost mask or event bit shows on `irq` in the cycle after the write. The bench sweeps all 256 mask/event combinations against `irq`. It also drives the FIFO through rounds of different fill levels, so the head passes the wrap point several times and every byte is compared with a queue model kept in the bench.

// File: rtl/utr_pkg.sv
package utr_pkg;
    localparam int UTR_EV_N      = 4;
    localparam int EVI_RXRDY     = 0;
    localparam int EVI_TXRDY     = 1;
    localparam int EVI_ERR       = 2;
    localparam int EVI_RXTO      = 3;
    localparam int UTR_BYTE_W    = 8;
    localparam logic [UTR_EV_N-1:0] UTR_BREAK_SRC = 4'b0011;

    typedef logic [UTR_EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/utr_rx_fifo.sv
module utr_rx_fifo #(
    parameter int DEPTH = 6,
    parameter int DW    = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int SUM_W = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [IDX_W-1:0]         head;
        logic [CNT_W-1:0]         cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [SUM_W-1:0] tail_sum;

    always_comb begin
        f_d      = f_q;
        tail_sum = SUM_W'(f_q.head) + SUM_W'(f_q.cnt);
        if (tail_sum >= SUM_W'(DEPTH)) begin
            tail_sum = tail_sum - SUM_W'(DEPTH);
        end
        if (push) begin
            f_d.mem[tail_sum[IDX_W-1:0]] = push_data;
        end
        if (pop) begin
            if (f_q.head == IDX_W'(DEPTH - 1)) begin
                f_d.head = '0;
            end else begin
                f_d.head = f_q.head + 1'b1;
            end
        end
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head_data = f_q.mem[f_q.head];
    assign count     = f_q.cnt;
    assign full      = (f_q.cnt == CNT_W'(DEPTH));
    assign empty     = (f_q.cnt == '0);

    // R8: the front end never pushes into a full FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the front end never pops an empty FIFO
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R8: the count stays within the depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/utr_tx_hold.sv
module utr_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          sent
);
    typedef struct packed {
        logic          busy;
        logic [DW-1:0] byte_v;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d  = h_q;
        sent = h_q.busy && ready;
        if (sent) begin
            h_d.busy = 1'b0;
        end
        if (load && !h_q.busy) begin
            h_d.busy   = 1'b1;
            h_d.byte_v = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign valid = h_q.busy;
    assign data  = h_q.byte_v;

    // R5: a pending byte is held unchanged until the shifter takes it
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));
    // R5: a taken byte leaves the holding register empty
    p_sent_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);
endmodule

// File: rtl/utr_irq.sv
module utr_irq
    import utr_pkg::*;
(
    input  ev_vec_t ev,
    input  ev_vec_t mask,
    output logic    irq
);
    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < UTR_EV_N; i++) begin
            irq = irq | (ev[i] & mask[i]);
        end
    end

    // R1: an all-zero mask can never raise the line
    always_comb begin
        p_irq_masked_r1: assert (mask != '0 || !irq);
    end
endmodule

// File: rtl/uart_task_regs.sv
module uart_task_regs
    import utr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int RX_DEPTH = 6,
    parameter int N_PSEL   = 4,
    parameter logic [ADDR_W-1:0] OFF_START_RX = 12'h000,
    parameter logic [ADDR_W-1:0] OFF_STOP_RX  = 12'h004,
    parameter logic [ADDR_W-1:0] OFF_START_TX = 12'h008,
    parameter logic [ADDR_W-1:0] OFF_STOP_TX  = 12'h00C,
    parameter logic [ADDR_W-1:0] OFF_EV_BASE  = 12'h040,
    parameter logic [ADDR_W-1:0] OFF_MASK     = 12'h080,
    parameter logic [ADDR_W-1:0] OFF_MASK_SET = 12'h084,
    parameter logic [ADDR_W-1:0] OFF_MASK_CLR = 12'h088,
    parameter logic [ADDR_W-1:0] OFF_ERRSRC   = 12'h0C0,
    parameter logic [ADDR_W-1:0] OFF_ENABLE   = 12'h0C4,
    parameter logic [ADDR_W-1:0] OFF_RXD      = 12'h100,
    parameter logic [ADDR_W-1:0] OFF_TXD      = 12'h104,
    parameter logic [ADDR_W-1:0] OFF_BAUD     = 12'h140,
    parameter logic [ADDR_W-1:0] OFF_PSEL     = 12'h180,
    parameter logic [31:0]       BAUD_RST     = 32'h0400_0000,
    localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  tx_valid,
    output logic [UTR_BYTE_W-1:0] tx_data,
    input  logic                  tx_ready,
    input  logic                  rx_valid,
    input  logic [UTR_BYTE_W-1:0] rx_data,
    output logic                  rx_ready,
    output logic [CNT_W-1:0]      rx_space,
    input  logic                  break_in,
    output logic                  irq
);
    typedef struct packed {
        logic [31:0]             en;
        ev_vec_t                 mask;
        ev_vec_t                 ev;
        ev_vec_t                 errsrc;
        logic                    rx_on;
        logic                    tx_on;
        logic [31:0]             baud;
        logic [N_PSEL-1:0][31:0] psel;
    } regs_t;

    regs_t r_d, r_q;

    logic                  wr_ok;
    logic                  task_one;
    logic                  tx_load;
    logic                  tx_sent;
    logic                  rx_push;
    logic                  rx_pop;
    logic [UTR_BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]      fifo_cnt;
    logic                  fifo_full;
    logic                  fifo_empty;

    assign wr_ok    = bus_wr_en && ((r_q.en != '0) || (bus_addr == OFF_ENABLE));
    assign task_one = (bus_wdata == 32'd1);
    assign rx_ready = r_q.rx_on && !fifo_full;
    assign rx_push  = rx_valid && rx_ready;
    assign rx_space = r_q.rx_on ? (CNT_W'(RX_DEPTH) - fifo_cnt) : '0;

    // next-state of all software-visible registers
    always_comb begin
        r_d     = r_q;
        tx_load = 1'b0;
        rx_pop  = 1'b0;

        if (wr_ok) begin
            case (bus_addr)
                OFF_START_RX: if (task_one) r_d.rx_on = 1'b1;
                OFF_STOP_RX: begin
                    if (task_one) begin
                        r_d.rx_on          = 1'b0;
                        r_d.ev[EVI_RXTO]   = 1'b1;
                    end
                end
                OFF_START_TX: if (task_one) r_d.tx_on = 1'b1;
                OFF_STOP_TX:  if (task_one) r_d.tx_on = 1'b0;
                OFF_MASK:     r_d.mask   = bus_wdata[UTR_EV_N-1:0];
                OFF_MASK_SET: r_d.mask   = r_q.mask | bus_wdata[UTR_EV_N-1:0];
                OFF_MASK_CLR: r_d.mask   = r_q.mask & ~bus_wdata[UTR_EV_N-1:0];
                OFF_ERRSRC:   r_d.errsrc = r_q.errsrc & ~bus_wdata[UTR_EV_N-1:0];
                OFF_ENABLE:   r_d.en     = bus_wdata;
                OFF_TXD:      tx_load    = r_q.tx_on && !tx_valid;
                OFF_BAUD:     r_d.baud   = bus_wdata;
                default: begin
                    for (int i = 0; i < UTR_EV_N; i++) begin
                        if (bus_addr == OFF_EV_BASE + ADDR_W'(4 * i)) begin
                            r_d.ev[i] = (bus_wdata != '0);
                        end
                    end
                    for (int p = 0; p < N_PSEL; p++) begin
                        if (bus_addr == OFF_PSEL + ADDR_W'(4 * p)) begin
                            r_d.psel[p] = bus_wdata;
                        end
                    end
                end
            endcase
        end

        // receive-data read consumes the head byte while receiving
        if (bus_rd_en && (bus_addr == OFF_RXD) && r_q.rx_on && !fifo_empty) begin
            rx_pop = 1'b1;
            if (fifo_cnt > CNT_W'(1)) begin
                r_d.ev[EVI_RXRDY] = 1'b1;
            end
        end

        // hardware event sources take priority over software writes
        if (rx_push) begin
            r_d.ev[EVI_RXRDY] = 1'b1;
        end
        if (tx_sent) begin
            r_d.ev[EVI_TXRDY] = 1'b1;
        end
        if (break_in) begin
            r_d.errsrc       = r_d.errsrc | UTR_BREAK_SRC;
            r_d.ev[EVI_ERR]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.psel <= '1;
            r_q.baud <= BAUD_RST;
        end else begin
            r_q <= r_d;
        end
    end

    // read multiplexer; write-only and unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MASK:   bus_rdata = 32'(r_q.mask);
            OFF_ERRSRC: bus_rdata = 32'(r_q.errsrc);
            OFF_ENABLE: bus_rdata = r_q.en;
            OFF_RXD:    bus_rdata = 32'(fifo_head);
            OFF_BAUD:   bus_rdata = r_q.baud;
            default: begin
                for (int i = 0; i < UTR_EV_N; i++) begin
                    if (bus_addr == OFF_EV_BASE + ADDR_W'(4 * i)) begin
                        bus_rdata = 32'(r_q.ev[i]);
                    end
                end
                for (int p = 0; p < N_PSEL; p++) begin
                    if (bus_addr == OFF_PSEL + ADDR_W'(4 * p)) begin
                        bus_rdata = r_q.psel[p];
                    end
                end
            end
        endcase
    end

    utr_rx_fifo #(
        .DEPTH (RX_DEPTH),
        .DW    (UTR_BYTE_W)
    ) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head_data (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    utr_tx_hold #(
        .DW (UTR_BYTE_W)
    ) u_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (bus_wdata[UTR_BYTE_W-1:0]),
        .ready     (tx_ready),
        .valid     (tx_valid),
        .data      (tx_data),
        .sent      (tx_sent)
    );

    utr_irq u_irq (
        .ev   (r_q.ev),
        .mask (r_q.mask),
        .irq  (irq)
    );

    // R4: a disabled block keeps its control state across non-enable writes
    p_disabled_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (r_q.en == '0) && (bus_addr != OFF_ENABLE))
        |=> ($stable(r_q.mask) && $stable(r_q.rx_on) && $stable(r_q.tx_on)));
    // R6: stop-receive ends reception and flags the timeout event
    p_stoprx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (r_q.en != '0) && (bus_addr == OFF_STOP_RX) && (bus_wdata == 32'd1))
        |=> (!r_q.rx_on && r_q.ev[EVI_RXTO]));
    // R3: a break always lands in the error source and the error event
    p_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        break_in |=> (r_q.ev[EVI_ERR] && (r_q.errsrc[1:0] == 2'b11)));
    // R8: nothing is stored while reception is stopped
    p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.rx_on && !rx_pop) |=> $stable(fifo_cnt));
endmodule

// File: tb/tb_uart_task_regs.sv
module tb_uart_task_regs;
    localparam logic [11:0] A_START_RX = 12'h000;
    localparam logic [11:0] A_STOP_RX  = 12'h004;
    localparam logic [11:0] A_START_TX = 12'h008;
    localparam logic [11:0] A_STOP_TX  = 12'h00C;
    localparam logic [11:0] A_EV       = 12'h040;
    localparam logic [11:0] A_MASK     = 12'h080;
    localparam logic [11:0] A_MSET     = 12'h084;
    localparam logic [11:0] A_MCLR     = 12'h088;
    localparam logic [11:0] A_ERRSRC   = 12'h0C0;
    localparam logic [11:0] A_ENABLE   = 12'h0C4;
    localparam logic [11:0] A_RXD      = 12'h100;
    localparam logic [11:0] A_TXD      = 12'h104;
    localparam logic [11:0] A_BAUD     = 12'h140;
    localparam logic [11:0] A_PSEL     = 12'h180;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic [2:0]  rx_space;
    logic        break_in = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] v;
    logic [7:0]  model_q[$];

    always #4 clk = ~clk;

    uart_task_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .rx_space  (rx_space),
        .break_in  (break_in),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        chk("R9 irq", 32'(irq), 0);
        chk("R9 tx_valid", 32'(tx_valid), 0);
        chk("R9 rx_ready", 32'(rx_ready), 0);
        chk("R9 rx_space", 32'(rx_space), 0);
        for (int p = 0; p < 4; p++) begin
            rd(A_PSEL + 12'(4 * p), v); chk("R9 psel", v, 32'hFFFF_FFFF);
        end
        rd(A_BAUD, v);   chk("R9 baud", v, 32'h0400_0000);
        rd(A_MASK, v);   chk("R9 mask", v, 0);
        rd(A_ENABLE, v); chk("R9 enable", v, 0);
        rd(A_ERRSRC, v); chk("R9 errsrc", v, 0);

        // R4 disabled writes ignored
        wr(A_MASK, 32'hF);
        rd(A_MASK, v); chk("R4 mask while disabled", v, 0);
        wr(A_START_RX, 1);
        chk("R4 start while disabled", 32'(rx_ready), 0);
        wr(A_ENABLE, 32'h4);
        wr(A_MASK, 32'hF);
        rd(A_MASK, v); chk("R4 mask after enable", v, 32'hF);

        // R2 mask sweep and aliases
        for (int m = 0; m < 16; m++) begin
            wr(A_MASK, 32'hFFFF_FFF0 | 32'(m));
            rd(A_MASK, v); chk("R2 mask write", v, 32'(m));
        end
        wr(A_MASK, 32'h5);
        wr(A_MSET, 32'h2);
        rd(A_MASK, v); chk("R2 set alias", v, 32'h7);
        wr(A_MCLR, 32'h5);
        rd(A_MASK, v); chk("R2 clear alias", v, 32'h2);

        // R1 / R10 full mask x event sweep
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 16; e++) begin
                wr(A_MASK, 32'(m));
                for (int i = 0; i < 4; i++) begin
                    wr(A_EV + 12'(4 * i), ((e >> i) & 1) != 0 ? (32'h1 << (i * 7)) : 32'h0);
                end
                chk("R1 irq", 32'(irq), 32'(((m & e) != 0) ? 1 : 0));
                if (m == 5) begin
                    for (int i = 0; i < 4; i++) begin
                        rd(A_EV + 12'(4 * i), v); chk("R10 event read", v, 32'((e >> i) & 1));
                    end
                end
            end
        end
        for (int i = 0; i < 4; i++) wr(A_EV + 12'(4 * i), 0);
        wr(A_MASK, 0);

        // R11 write-only and unmapped
        rd(12'h7F0, v);    chk("R11 unmapped", v, 0);
        rd(A_TXD, v);      chk("R11 txd", v, 0);
        rd(A_START_TX, v); chk("R11 task", v, 0);
        rd(A_MSET, v);     chk("R11 mask alias", v, 0);

        // R5 / R6 transmit path
        wr(A_TXD, 32'h11);
        chk("R5 txd before start", 32'(tx_valid), 0);
        wr(A_START_TX, 2);
        wr(A_TXD, 32'h12);
        chk("R6 start needs value 1", 32'(tx_valid), 0);
        wr(A_START_TX, 1);
        wr(A_TXD, 32'hA5);
        chk("R5 tx_valid", 32'(tx_valid), 1);
        chk("R5 tx_data", 32'(tx_data), 32'hA5);
        wr(A_TXD, 32'h3C);
        chk("R5 pending keeps byte", 32'(tx_data), 32'hA5);
        rd(A_EV + 12'h4, v); chk("R5 txrdy before send", v, 0);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
        chk("R5 tx_valid after send", 32'(tx_valid), 0);
        rd(A_EV + 12'h4, v); chk("R5 txrdy after send", v, 1);
        wr(A_TXD, 32'h5A);
        chk("R5 next byte", 32'(tx_data), 32'h5A);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
        wr(A_STOP_TX, 1);
        wr(A_TXD, 32'h77);
        chk("R6 stop tx", 32'(tx_valid), 0);
        rd(A_EV + 12'hC, v); chk("R6 stop tx leaves rxto", v, 0);

        // R8 / R7 FIFO rounds with wrap
        wr(A_START_RX, 1);
        chk("R8 rx_ready started", 32'(rx_ready), 1);
        for (int r = 0; r < 5; r++) begin
            int k;
            k = ((r * 5) % DEPTH) + 1;
            for (int i = 0; i < k; i++) begin
                chk("R8 rx_space", 32'(rx_space), 32'(DEPTH - model_q.size()));
                wr(A_EV, 0);
                push(8'(r * 16 + i + 1));
                model_q.push_back(8'(r * 16 + i + 1));
                rd(A_EV, v); chk("R8 push sets rxrdy", v, 1);
            end
            if (model_q.size() == DEPTH) begin
                chk("R8 full", 32'(rx_ready), 0);
                push(8'hEE);
            end
            while (model_q.size() > 0) begin
                logic [7:0] exp_b;
                exp_b = model_q.pop_front();
                wr(A_EV, 0);
                rd(A_RXD, v); chk("R7 rx byte", v, 32'(exp_b));
                rd(A_EV, v);  chk("R7 rxrdy re-set", v, 32'(model_q.size() > 0));
            end
        end
        wr(A_EV, 0);
        rd(A_RXD, v);
        rd(A_EV, v); chk("R7 empty read", v, 0);
        chk("R7 no underflow", 32'(rx_space), DEPTH);

        // R6 / R7 / R8 stop receive
        push(8'hE1);
        push(8'hE2);
        wr(A_MASK, 32'h8);
        wr(A_STOP_RX, 1);
        chk("R6 rx stopped", 32'(rx_ready), 0);
        chk("R8 space when stopped", 32'(rx_space), 0);
        chk("R1 rxto irq", 32'(irq), 1);
        rd(A_EV + 12'hC, v); chk("R6 rxto", v, 1);
        rd(A_RXD, v); chk("R7 no pop when stopped", v, 32'hE1);
        rd(A_RXD, v); chk("R7 no pop when stopped 2", v, 32'hE1);
        wr(A_EV, 0);
        push(8'hE3);
        rd(A_EV, v); chk("R8 ignored push", v, 0);
        wr(A_START_RX, 1);
        rd(A_RXD, v); chk("R7 after restart", v, 32'hE1);
        rd(A_RXD, v); chk("R7 after restart 2", v, 32'hE2);
        chk("R8 stopped push dropped", 32'(rx_space), DEPTH);

        // R3 break and error source
        wr(A_MASK, 32'h4);
        @(negedge clk) break_in = 1'b1;
        @(negedge clk) break_in = 1'b0;
        rd(A_ERRSRC, v);     chk("R3 break source", v, 3);
        rd(A_EV + 12'h8, v); chk("R3 error event", v, 1);
        chk("R3 error irq", 32'(irq), 1);
        wr(A_ERRSRC, 1);
        rd(A_ERRSRC, v); chk("R3 w1c bit0", v, 2);
        wr(A_ERRSRC, 2);
        rd(A_ERRSRC, v); chk("R3 w1c bit1", v, 0);
        rd(A_EV + 12'h8, v); chk("R3 event kept", v, 1);

        // R4 disable again
        wr(A_ENABLE, 0);
        wr(A_EV + 12'h8, 0);
        rd(A_EV + 12'h8, v); chk("R4 event write ignored", v, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule